// File: doc/BRIEF.md
# Paced Parallel Output Controller with Request/Acknowledge

This block owns a parallel digital output register and decides when a new word goes onto it. Words come either from an output FIFO or, with FIFO mode off, from single-cycle host write pulses. In FIFO mode a word can be moved as soon as one is available. It can also be paced by a timer: each high-to-low transition of an external counter output moves one word.

After a word lands on the output register, the controller can announce it with a one-cycle request strobe. If acknowledge mode is also on, it then stalls until the receiving peripheral raises its acknowledge line. A timeout limits how long it waits. If the timeout expires, a sticky error flag is set and the controller resumes. The mode bits are static configuration inputs. The counter output and the acknowledge line are asynchronous and are synchronized inside the block.

Top module: `dout_hs_ctrl`

## Requirements
- R1: After reset, `do_data` is 0, and `do_req`, `fifo_rd` and `ack_err` are all 0.
- R2: With FIFO mode on and timer mode off, the controller takes a word whenever the FIFO is not empty and no word is in progress. The FIFO is first-word-fall-through: `fifo_rdata` shows the head word whenever `fifo_empty` is low, and a one-cycle `fifo_rd` pulse removes that word. The word is on `do_data` during the cycle in which `fifo_rd` is high. `fifo_rd` is never high in two consecutive cycles, and words reach `do_data` in FIFO order.
- R3: With FIFO mode and timer mode on, each synchronized high-to-low transition of `cnt1_out` moves exactly one word. No word moves while `cnt1_out` is static. A transition that occurs while the FIFO is empty is discarded and is not remembered.
- R4: With request mode on, `do_req` is high for exactly one cycle, in the cycle that follows the one in which `do_data` took the new word. With request mode off, `do_req` stays low.
- R5: While the FIFO is empty, `do_data` keeps its last value and `fifo_rd` stays low. `do_data` changes only when a word is loaded.
- R6: With request mode and acknowledge mode both on, no further word is taken after a request until a rising edge of `ext_ack` (synchronized) is seen.
- R7: If no acknowledge edge arrives within `ACK_TIMEOUT` cycles of waiting, `ack_err` goes high and stays high until reset, and the controller goes on to the next word.
- R8: With FIFO mode off, a `host_wr` pulse puts `host_wdata` on `do_data` and follows the same request/acknowledge sequence. The FIFO is never read in this mode.
- R9: A `host_wr` pulse that arrives while a word is still in progress is discarded, and `do_data` keeps the earlier word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ack_en | input | 1 | Wait for acknowledge after each request |
| cfg_req_en | input | 1 | Issue a request strobe per new word |
| cfg_timer_en | input | 1 | Pace FIFO words on counter falling edges |
| cfg_fifo_en | input | 1 | Source words from the FIFO (else host writes) |
| fifo_rdata | input | DATA_W | Head word of the output FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rd | output | 1 | One-cycle pop of the FIFO head |
| host_wr | input | 1 | Host write pulse (FIFO mode off) |
| host_wdata | input | DATA_W | Host write data |
| cnt1_out | input | 1 | Asynchronous pacing counter output |
| ext_ack | input | 1 | Asynchronous peripheral acknowledge |
| do_data | output | DATA_W | Parallel output register |
| do_req | output | 1 | One-cycle request strobe |
| ack_err | output | 1 | Sticky acknowledge-timeout flag |

## Verification
The assertions check several properties on every cycle: the request strobe is one cycle wide and comes right after a load, FIFO pops are single-cycle and only follow a non-empty cycle, the output register is frozen outside the load step, and the error flag only rises from the acknowledge wait and then stays set. Other behaviour only shows up in the bench scenarios. These cover FIFO ordering, one word per counter falling edge, falling edges dropped while the FIFO is empty, the stall until an acknowledge arrives, recovery after a timeout, and host writes that are discarded while a word is in progress.

// File: rtl/dout_hs_pkg.sv
package dout_hs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_LOAD     = 2'd1,
        ST_STROBE   = 2'd2,
        ST_WAIT_ACK = 2'd3
    } hs_state_e;

    typedef struct packed {
        logic ack_en;
        logic req_en;
        logic timer_en;
        logic fifo_en;
    } hs_mode_t;

    // Decide whether a new word may start from the idle state.
    function automatic logic word_ready(hs_mode_t m, logic empty, logic tfall, logic hwr);
        if (m.fifo_en)
            return !empty && (!m.timer_en || tfall);
        return hwr;
    endfunction

endpackage

// File: rtl/dout_edge_sync.sv
module dout_edge_sync #(
    parameter int STAGES      = 2,
    parameter bit DETECT_RISE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic pulse
);
    localparam int MSB = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
            last  <= chain[MSB];
        end
    end

    generate
        if (DETECT_RISE) begin : g_rise
            assign pulse = chain[MSB] & ~last;
        end else begin : g_fall
            assign pulse = ~chain[MSB] & last;
        end
    endgenerate

endmodule

// File: rtl/dout_ack_timer.sv
module dout_ack_timer #(
    parameter int LIMIT  = 64,
    parameter bit ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign expired = ENABLE && run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/dout_hs_ctrl.sv
module dout_hs_ctrl
    import dout_hs_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ACK_TIMEOUT = 64,
    parameter bit TIMEOUT_EN  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_ack_en,
    input  logic              cfg_req_en,
    input  logic              cfg_timer_en,
    input  logic              cfg_fifo_en,
    input  logic [DATA_W-1:0] fifo_rdata,
    input  logic              fifo_empty,
    output logic              fifo_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              cnt1_out,
    input  logic              ext_ack,
    output logic [DATA_W-1:0] do_data,
    output logic              do_req,
    output logic              ack_err
);
    hs_mode_t          mode;
    hs_state_e         state_q, state_d;
    logic [DATA_W-1:0] do_q;
    logic              from_fifo_q;
    logic              err_q;
    logic              tfall, ack_rise, tmo, start;

    assign mode = '{ack_en: cfg_ack_en, req_en: cfg_req_en,
                    timer_en: cfg_timer_en, fifo_en: cfg_fifo_en};

    dout_edge_sync #(.STAGES(SYNC_STAGES), .DETECT_RISE(1'b0)) u_cnt_sync (
        .clk(clk), .rst(rst), .d(cnt1_out), .pulse(tfall)
    );

    dout_edge_sync #(.STAGES(SYNC_STAGES), .DETECT_RISE(1'b1)) u_ack_sync (
        .clk(clk), .rst(rst), .d(ext_ack), .pulse(ack_rise)
    );

    dout_ack_timer #(.LIMIT(ACK_TIMEOUT), .ENABLE(TIMEOUT_EN)) u_timer (
        .clk(clk), .rst(rst), .run(state_q == ST_WAIT_ACK), .expired(tmo)
    );

    assign start = (state_q == ST_IDLE) && word_ready(mode, fifo_empty, tfall, host_wr);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_LOAD;
            ST_LOAD:     state_d = mode.req_en ? ST_STROBE : ST_IDLE;
            ST_STROBE:   state_d = mode.ack_en ? ST_WAIT_ACK : ST_IDLE;
            ST_WAIT_ACK: if (ack_rise || tmo) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            do_q        <= '0;
            from_fifo_q <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                do_q        <= mode.fifo_en ? fifo_rdata : host_wdata;
                from_fifo_q <= mode.fifo_en;
            end
            if (state_q == ST_WAIT_ACK && tmo && !ack_rise)
                err_q <= 1'b1;
        end
    end

    assign do_data = do_q;
    assign fifo_rd = (state_q == ST_LOAD) && from_fifo_q;
    assign do_req  = (state_q == ST_STROBE);
    assign ack_err = err_q;

endmodule

// File: rtl/dout_hs_ctrl_chk.sv
module dout_hs_ctrl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              fifo_rd,
    input logic              fifo_empty,
    input logic              do_req,
    input logic [DATA_W-1:0] do_data,
    input logic              ack_err,
    input logic              in_load,
    input logic              in_wait
);
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        do_req |=> !do_req);                                   // R4
    AST_REQ_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        do_req |-> $past(in_load));                            // R4
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |=> !fifo_rd);                                 // R2
    AST_RD_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> !$past(fifo_empty));                       // R5
    AST_DO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_load |-> $stable(do_data));                        // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ack_err |=> ack_err);                                  // R7
    AST_ERR_FROM_WAIT: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_err) |-> $past(in_wait));                    // R7
endmodule

bind dout_hs_ctrl dout_hs_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .fifo_rd(fifo_rd), .fifo_empty(fifo_empty),
    .do_req(do_req), .do_data(do_data), .ack_err(ack_err),
    .in_load(state_q == dout_hs_pkg::ST_LOAD),
    .in_wait(state_q == dout_hs_pkg::ST_WAIT_ACK)
);

// File: tb/dout_hs_ctrl_tb.sv
`timescale 1ns/1ps
module dout_hs_ctrl_tb;
    localparam int W = 16;

    logic clk = 0, rst = 1;
    logic cfg_ack_en = 0, cfg_req_en = 0, cfg_timer_en = 0, cfg_fifo_en = 0;
    logic [W-1:0] fifo_rdata = '0;
    logic fifo_empty = 1;
    logic fifo_rd;
    logic host_wr = 0;
    logic [W-1:0] host_wdata = '0;
    logic cnt1_out = 1, ext_ack = 0;
    logic [W-1:0] do_data;
    logic do_req, ack_err;

    int n_chk = 0, n_fail = 0, rd_cnt = 0, req_cnt = 0;
    bit req_prev = 0, rd_prev = 0, auto_ack = 0, finished = 0;
    logic [W-1:0] fq[$];
    logic [W-1:0] pq[$];

    always #2 clk = ~clk;

    dout_hs_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_ack_en(cfg_ack_en), .cfg_req_en(cfg_req_en),
        .cfg_timer_en(cfg_timer_en), .cfg_fifo_en(cfg_fifo_en),
        .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .cnt1_out(cnt1_out),
        .ext_ack(ext_ack), .do_data(do_data), .do_req(do_req), .ack_err(ack_err)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // FIFO model: first-word-fall-through, pop seen during the read cycle
    initial forever begin
        @(negedge clk);
        if (!rst && fifo_rd) begin
            chk(fq.size() > 0 && do_data == fq[0], "R2 order", 32'(do_data),
                fq.size() > 0 ? 32'(fq[0]) : 32'hDEAD);
            if (fq.size() > 0) void'(fq.pop_front());
            rd_cnt++;
        end
        while (pq.size() > 0) fq.push_back(pq.pop_front());
        fifo_empty = (fq.size() == 0);
        fifo_rdata = (fq.size() > 0) ? fq[0] : '0;
    end

    // Request monitor
    initial forever begin
        @(negedge clk);
        if (rst) begin
            req_prev = 0; rd_prev = 0;
        end else begin
            if (do_req) begin
                req_cnt++;
                chk(!req_prev, "R4 width", 32'(req_prev), 0);
                if (cfg_fifo_en) chk(rd_prev, "R4 follows load", 32'(rd_prev), 1);
            end
            req_prev = do_req;
            rd_prev  = fifo_rd;
        end
    end

    // Automatic acknowledge responder
    initial forever begin
        @(negedge clk);
        if (auto_ack && do_req) begin
            repeat ($urandom_range(0, 5)) @(negedge clk);
            ext_ack = 1;
            repeat (3) @(negedge clk);
            ext_ack = 0;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit f, input bit t, input bit r, input bit a);
        @(negedge clk);
        rst = 1;
        cfg_fifo_en = f; cfg_timer_en = t; cfg_req_en = r; cfg_ack_en = a;
        fq.delete(); pq.delete();
        fifo_empty = 1; fifo_rdata = '0;
        cnt1_out = 1; ext_ack = 0; host_wr = 0;
        cycles(3);
        rd_cnt = 0; req_cnt = 0;
        rst = 0;
    endtask

    task automatic push(input logic [W-1:0] w);
        pq.push_back(w);
    endtask

    task automatic cnt_fall();
        cnt1_out = 0;
        cycles(4);
        cnt1_out = 1;
        cycles(4);
    endtask

    task automatic host_write(input logic [W-1:0] w);
        host_wdata = w; host_wr = 1;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic give_ack();
        ext_ack = 1; cycles(4); ext_ack = 0; cycles(2);
    endtask

    function automatic logic [W-1:0] rword();
        return W'($urandom);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] w[5];
        logic [W-1:0] ha, hb, hc;
        void'($urandom(32'h5EED_0042));

        // R1: reset state
        do_reset(1, 0, 0, 0);
        chk(do_data == 0, "R1 do_data", 32'(do_data), 0);
        chk(!do_req, "R1 do_req", 32'(do_req), 0);
        chk(!fifo_rd, "R1 fifo_rd", 32'(fifo_rd), 0);
        chk(!ack_err, "R1 ack_err", 32'(ack_err), 0);

        // R2: free-running FIFO drain, no request strobes
        foreach (w[i]) begin w[i] = rword(); push(w[i]); end
        cycles(30);
        chk(fq.size() == 0, "R2 drained", fq.size(), 0);
        chk(do_data == w[4], "R2 last word", 32'(do_data), 32'(w[4]));
        chk(rd_cnt == 5, "R2 pops", rd_cnt, 5);
        chk(req_cnt == 0, "R4 no req when off", req_cnt, 0);

        // R5: empty FIFO holds output
        cycles(20);
        chk(do_data == w[4], "R5 hold", 32'(do_data), 32'(w[4]));
        chk(rd_cnt == 5, "R5 no pop", rd_cnt, 5);

        // R3: timer pacing
        do_reset(1, 1, 0, 0);
        for (int i = 0; i < 3; i++) begin w[i] = rword(); push(w[i]); end
        cycles(20);
        chk(fq.size() == 3, "R3 static counter", fq.size(), 3);
        chk(do_data == 0, "R3 no move", 32'(do_data), 0);
        cnt_fall(); cycles(4);
        chk(fq.size() == 2, "R3 one word per fall", fq.size(), 2);
        chk(do_data == w[0], "R3 first word", 32'(do_data), 32'(w[0]));
        cnt_fall(); cycles(4);
        chk(do_data == w[1], "R3 second word", 32'(do_data), 32'(w[1]));
        cnt_fall(); cycles(4);
        chk(fq.size() == 0, "R3 drained", fq.size(), 0);
        cnt_fall();
        w[3] = rword(); push(w[3]);
        cycles(20);
        chk(fq.size() == 1, "R3 fall on empty dropped", fq.size(), 1);
        chk(do_data == w[2], "R3 hold after drop", 32'(do_data), 32'(w[2]));
        cnt_fall(); cycles(4);
        chk(do_data == w[3], "R3 later fall moves", 32'(do_data), 32'(w[3]));

        // R4: request strobes
        do_reset(1, 0, 1, 0);
        for (int i = 0; i < 4; i++) push(rword());
        cycles(30);
        chk(req_cnt == 4, "R4 one req per word", req_cnt, 4);

        // R6: acknowledge stall, then R7 timeout
        do_reset(1, 0, 1, 1);
        for (int i = 0; i < 3; i++) begin w[i] = rword(); push(w[i]); end
        cycles(30);
        chk(rd_cnt == 1, "R6 stall until ack", rd_cnt, 1);
        chk(req_cnt == 1, "R6 single req", req_cnt, 1);
        chk(do_data == w[0], "R6 word held", 32'(do_data), 32'(w[0]));
        give_ack(); cycles(10);
        chk(rd_cnt == 2, "R6 resume after ack", rd_cnt, 2);
        chk(do_data == w[1], "R6 next word", 32'(do_data), 32'(w[1]));
        chk(!ack_err, "R7 no error yet", 32'(ack_err), 0);
        cycles(100);
        chk(ack_err, "R7 timeout flag", 32'(ack_err), 1);
        chk(rd_cnt == 3, "R7 resumes after timeout", rd_cnt, 3);
        cycles(100);
        chk(ack_err, "R7 flag sticky", 32'(ack_err), 1);

        // R8 / R9: host writes
        do_reset(0, 0, 1, 1);
        auto_ack = 1;
        ha = rword(); hb = rword(); hc = ~hb;
        host_write(ha); cycles(30);
        chk(do_data == ha, "R8 host word", 32'(do_data), 32'(ha));
        chk(req_cnt == 1, "R8 req issued", req_cnt, 1);
        host_write(hb); cycles(1);
        host_write(hc); cycles(30);
        chk(do_data == hb, "R9 busy write dropped", 32'(do_data), 32'(hb));
        chk(req_cnt == 2, "R9 req count", req_cnt, 2);
        chk(rd_cnt == 0, "R8 no FIFO read", rd_cnt, 0);
        chk(!ack_err, "R7 no timeout with ack", 32'(ack_err), 0);

        // Random traffic in FIFO mode with handshake (R2, R4, R6)
        do_reset(1, 0, 1, 1);
        for (int i = 0; i < 40; i++) begin
            push(rword());
            cycles($urandom_range(0, 6));
        end
        while (fq.size() > 0 || pq.size() > 0) cycles(1);
        cycles(40);
        chk(rd_cnt == 40, "R2 random pops", rd_cnt, 40);
        chk(req_cnt == 40, "R4 random reqs", req_cnt, 40);
        chk(!ack_err, "R6 random no timeout", 32'(ack_err), 0);
        auto_ack = 0;

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule